// File: doc/BRIEF.md
# Frame-Synchronised Converter Serial Port

This block is the serial front end of a sampling converter when the converter is driven by a signal processor's framed serial port. The mode is chosen each time chip select falls. If the receive frame-sync input is low at that moment, the framed mode is armed. If it is high, the block stays silent and the ordinary select-framed serial logic, which lives elsewhere, owns the pins. Once armed, chip select may stay low across any number of conversions, and each falling edge of the receive frame-sync input opens a new transaction.

Inside a transaction, the serial clock edges are counted. Each clock cycle is one falling edge followed by one rising edge. Command bits enter on falling edges. The first three bits, sent most significant first, pick the input channel, and acquisition starts on the third falling edge. The input word is captured on a fixed rising edge. A one-cycle transmit frame-sync pulse follows on the next rising edge, and the captured word then leaves most significant bit first on rising edges. A framing-select input, latched when the frame opens, chooses short framing (24 clock cycles) or long framing (32 clock cycles). Long framing stretches acquisition by eight cycles. All pin inputs are treated as synchronous to `clk` and are edge-detected against their previous sampled value, so every event takes effect on the `clk` edge at which the new pin level is first seen.

Top module: `fsync_adc_port`

## Requirements
- R1: When `cs_n` falls with `fs_rx` low, `framed` goes to 1. When `cs_n` falls with `fs_rx` high, `framed` stays 0, and `fs_tx`, `acq`, `smp_stb` and `sdo` stay 0 whatever `sclk` and `fs_rx` do.
- R2: Command bits are taken on falling `sclk` edges, starting with the first falling edge after `fs_rx` falls. On the third falling edge, `chan` becomes the first three bits received (the first bit is `chan[2]`) and `acq` rises. `chan` does not change while `acq` stays high.
- R3: Command bits after the third have no effect on `chan` or on the timing of `acq`, `smp_stb`, `fs_tx` or `sdo`. This covers the scan-selection bits and the extra bits of long framing.
- R4: `smp_data` is captured on the rising edge of the 7th clock cycle in short framing and the 15th in long framing. On that edge, `smp_stb` goes high for exactly one `clk` cycle and `acq` falls.
- R5: `fs_tx` rises on the rising edge of the 8th clock cycle (short framing) or the 16th (long framing). It falls on the next rising edge, so it is exactly one `sclk` period wide.
- R6: The captured word appears on `sdo`, most significant bit first, one bit per rising edge. This covers rising edges 9 to 24 in short framing and 17 to 32 in long framing. Every later rising edge before the next frame drives 0.
- R7: `cs_n` high aborts any transaction. `framed`, `acq`, `fs_tx`, `sdo` and `chan` are 0, and the next `cs_n` fall chooses the mode afresh.
- R8: A falling edge of `fs_rx` in the middle of a transaction abandons it. `acq`, `fs_tx` and `sdo` drop to 0, and clock counting restarts from the first cycle.
- R9: `wide` is sampled only when `fs_rx` falls (1 selects long framing). Changing it during the transaction does not change that frame's timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| fs_rx | input | 1 | Receive frame sync; its falling edge opens a transaction |
| sclk | input | 1 | Serial clock from the signal processor |
| sdi | input | 1 | Serial command data |
| wide | input | 1 | Framing select: 1 long, 0 short |
| smp_data | input | 16 | Converter word captured at the sample edge |
| framed | output | 1 | Framed mode armed |
| chan | output | 3 | Selected input channel |
| acq | output | 1 | Acquisition in progress |
| smp_stb | output | 1 | One-cycle pulse at the sample edge |
| fs_tx | output | 1 | Transmit frame sync |
| sdo | output | 1 | Serial result data |

## Verification
Any fault in the clock-cycle counter shifts `acq`, `smp_stb` and `fs_tx` by whole `sclk` periods. A fault in the latched framing select moves the sample edge by eight cycles. Both show up at the first event of the frame, no later than the sample edge. A bad output shift register corrupts a specific `sdo` bit within the sixteen data edges, or leaves non-zero bits in the trailing zero field. A mode latch that is not cleared, or not re-evaluated, shows as pulses on `fs_tx` or `acq` in what should be a silent selection.

// File: rtl/fsync_adc_port.sv
module fsync_adc_port #(
  parameter int RES_W     = 16,
  parameter int CH_W      = 3,
  parameter int CNT_W     = 6,
  parameter int SHORT_SMP = 7,
  parameter int LONG_SMP  = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             fs_rx,
  input  logic             sclk,
  input  logic             sdi,
  input  logic             wide,
  input  logic [RES_W-1:0] smp_data,
  output logic             framed,
  output logic [CH_W-1:0]  chan,
  output logic             acq,
  output logic             smp_stb,
  output logic             fs_tx,
  output logic             sdo
);
  localparam logic [CNT_W-1:0] CH_LAST = CNT_W'(CH_W - 1);
  localparam logic [CNT_W-1:0] SMP_S   = CNT_W'(SHORT_SMP);
  localparam logic [CNT_W-1:0] SMP_L   = CNT_W'(LONG_SMP);

  logic cs_d, fs_d, sclk_d;
  logic active, wide_q;
  logic [CNT_W-1:0] nf;
  logic [CH_W-2:0]  ch_sh;
  logic [RES_W-1:0] sh;

  wire cs_fall  = cs_d & ~cs_n;
  wire fs_fall  = fs_d & ~fs_rx;
  wire s_rise   = sclk & ~sclk_d;
  wire s_fall   = ~sclk & sclk_d;
  wire frame_go = framed & fs_fall;

  wire [CNT_W-1:0] smp_at = wide_q ? SMP_L : SMP_S;
  wire [CNT_W-1:0] ftx_at = smp_at + CNT_W'(1);
  wire [CNT_W-1:0] dat_at = smp_at + CNT_W'(2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d    <= 1'b1;
      fs_d    <= 1'b0;
      sclk_d  <= 1'b0;
      framed  <= 1'b0;
      active  <= 1'b0;
      wide_q  <= 1'b0;
      nf      <= '0;
      ch_sh   <= '0;
      sh      <= '0;
      chan    <= '0;
      acq     <= 1'b0;
      smp_stb <= 1'b0;
      fs_tx   <= 1'b0;
      sdo     <= 1'b0;
    end else begin
      cs_d    <= cs_n;
      fs_d    <= fs_rx;
      sclk_d  <= sclk;
      smp_stb <= 1'b0;
      if (cs_n) begin
        framed <= 1'b0;
        active <= 1'b0;
        nf     <= '0;
        sh     <= '0;
        chan   <= '0;
        acq    <= 1'b0;
        fs_tx  <= 1'b0;
        sdo    <= 1'b0;
      end else if (cs_fall) begin
        framed <= ~fs_rx;
      end else if (frame_go) begin
        active <= 1'b1;
        wide_q <= wide;
        nf     <= '0;
        ch_sh  <= '0;
        sh     <= '0;
        acq    <= 1'b0;
        fs_tx  <= 1'b0;
        sdo    <= 1'b0;
      end else if (active) begin
        if (s_fall) begin
          if (nf != '1) nf <= nf + CNT_W'(1);
          if (nf < CH_LAST) ch_sh <= {ch_sh[CH_W-3:0], sdi};
          if (nf == CH_LAST) begin
            chan <= {ch_sh, sdi};
            acq  <= 1'b1;
          end
        end else if (s_rise) begin
          if (nf == smp_at) begin
            acq     <= 1'b0;
            smp_stb <= 1'b1;
            sh      <= smp_data;
          end
          fs_tx <= (nf == ftx_at);
          if (nf >= dat_at) begin
            sdo <= sh[RES_W-1];
            sh  <= {sh[RES_W-2:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/fsync_adc_port_chk.sv
module fsync_adc_port_chk #(
  parameter int CH_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cs_n,
  input logic            fs_rx,
  input logic            sclk,
  input logic            framed,
  input logic [CH_W-1:0] chan,
  input logic            acq,
  input logic            smp_stb,
  input logic            fs_tx,
  input logic            sdo
);
  logic sclk_p, cs_p, fs_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= 1'b0;
      cs_p   <= 1'b0;
      fs_p   <= 1'b0;
    end else begin
      sclk_p <= sclk;
      cs_p   <= cs_n;
      fs_p   <= fs_rx;
    end
  end

  p_silent_normal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !framed |-> (!fs_tx && !acq && !sdo));

  p_chan_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acq && $past(acq)) |-> $stable(chan));

  p_stb_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |=> !smp_stb);

  p_acq_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |-> !acq);

  p_tx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_tx && !(sclk && !sclk_p) && !cs_n && !(fs_p && !fs_rx)) |=> fs_tx);

  p_tx_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_tx && sclk && !sclk_p) |=> !fs_tx);

  p_deselect_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && cs_p) |-> (!framed && !fs_tx && !sdo && !acq && !smp_stb && chan == '0));
endmodule

bind fsync_adc_port fsync_adc_port_chk #(.CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .fs_rx(fs_rx), .sclk(sclk),
  .framed(framed), .chan(chan), .acq(acq), .smp_stb(smp_stb),
  .fs_tx(fs_tx), .sdo(sdo)
);

// File: tb/fsync_adc_port_test.sv
module fsync_adc_port_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, cs_n, fs_rx, sclk, sdi, wide;
  logic [15:0] smp_data;
  logic framed, acq, smp_stb, fs_tx, sdo;
  logic [2:0] chan;
  int checks = 0;
  int errors = 0;

  fsync_adc_port uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .fs_rx(fs_rx), .sclk(sclk),
    .sdi(sdi), .wide(wide), .smp_data(smp_data), .framed(framed),
    .chan(chan), .acq(acq), .smp_stb(smp_stb), .fs_tx(fs_tx), .sdo(sdo)
  );

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_frame(input bit w, input logic [15:0] cmdw, input logic [15:0] data,
                           input int stop_at, input bit flip);
    int s;
    string fx;
    s = w ? 15 : 7;
    fx = flip ? " R9 framing held" : "";
    smp_data = data;
    wide = w;
    fs_rx = 1'b1; tick;
    fs_rx = 1'b0; tick;
    for (int n = 1; n <= s + 20; n++) begin
      logic exp_sdo;
      if (n == stop_at) return;
      sclk = 1'b0;
      sdi = (n <= 16) ? cmdw[16-n] : 1'b0;
      tick;
      if (flip && n == 2) wide = ~w;
      chk({"R2 acq after fall", fx}, acq, (n >= 3 && n <= s));
      if (n == 3) chk({"R2 R3 chan", fx}, chan, cmdw[15:13]);
      sclk = 1'b1;
      tick;
      exp_sdo = (n >= s + 2 && n <= s + 17) ? data[15-(n-s-2)] : 1'b0;
      chk({"R4 smp_stb", fx}, smp_stb, (n == s));
      chk({"R4 acq after rise", fx}, acq, (n >= 3 && n < s));
      chk({"R5 fs_tx", fx}, fs_tx, (n == s + 1));
      chk({"R6 sdo", fx}, sdo, exp_sdo);
    end
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; fs_rx = 1'b0; sclk = 1'b1;
    sdi = 1'b0; wide = 1'b0; smp_data = '0;
    tick; tick; tick;
    rst_n = 1'b1;
    tick;
    chk("reset framed", framed, 0);
    chk("reset fs_tx", fs_tx, 0);
    chk("reset sdo", sdo, 0);
    chk("reset acq", acq, 0);
    chk("reset chan", chan, 0);

    // R1: selection with fs_rx high leaves the framed mode off
    fs_rx = 1'b1; cs_n = 1'b0; tick;
    chk("R1 framed off", framed, 0);
    fs_rx = 1'b0; tick;
    for (int k = 0; k < 20; k++) begin
      sclk = 1'b0; sdi = k[0]; tick;
      sclk = 1'b1; tick;
      chk("R1 fs_tx silent", fs_tx, 0);
      chk("R1 acq silent", acq, 0);
      chk("R1 sdo silent", sdo, 0);
    end
    cs_n = 1'b1; tick;
    cs_n = 1'b0; tick;
    chk("R1 framed on", framed, 1);

    // R2 R3 R4 R5 R6: sweep channels and both framings, other command bits varied
    for (int w = 0; w < 2; w++) begin
      for (int ch = 0; ch < 8; ch++) begin
        logic [15:0] cmdw, data;
        cmdw = {3'(ch), 5'(ch * 7 + w * 13), 8'(ch * 29 + 5)};
        data = 16'(32'hA5C3 ^ (ch * 32'h1357) ^ (w != 0 ? 32'h0F0F : 32'h0));
        run_frame(w[0], cmdw, data, 0, 1'b0);
      end
    end

    // R9: framing select flipped mid-frame
    run_frame(1'b0, 16'hB3C1, 16'h8E71, 0, 1'b1);
    run_frame(1'b1, 16'h4F00, 16'h1F2E, 0, 1'b1);

    // R8: restart while data is shifting out
    run_frame(1'b0, 16'h6000, 16'hFFFF, 13, 1'b0);
    chk("R8 sdo before restart", sdo, 1);
    fs_rx = 1'b1; tick;
    fs_rx = 1'b0; tick;
    chk("R8 sdo cleared", sdo, 0);
    chk("R8 acq cleared", acq, 0);
    // R8: restart while fs_tx is high
    run_frame(1'b1, 16'hE000, 16'h0001, 17, 1'b0);
    chk("R8 fs_tx before restart", fs_tx, 1);
    fs_rx = 1'b1; tick;
    fs_rx = 1'b0; tick;
    chk("R8 fs_tx cleared", fs_tx, 0);
    run_frame(1'b0, 16'h2000, 16'h5AA5, 0, 1'b0);
    // R8: restart during acquisition, then a full frame
    run_frame(1'b1, 16'hA000, 16'h0000, 6, 1'b0);
    chk("R8 acq before restart", acq, 1);
    run_frame(1'b1, 16'h8000, 16'hC3C3, 0, 1'b0);

    // R7: deselect mid-frame aborts and re-evaluates the mode
    run_frame(1'b0, 16'hE000, 16'h1234, 5, 1'b0);
    chk("R7 acq before abort", acq, 1);
    cs_n = 1'b1; tick;
    chk("R7 framed cleared", framed, 0);
    chk("R7 acq cleared", acq, 0);
    chk("R7 chan cleared", chan, 0);
    fs_rx = 1'b1; cs_n = 1'b0; tick;
    chk("R7 mode re-evaluated normal", framed, 0);
    fs_rx = 1'b0; tick;
    for (int k = 0; k < 12; k++) begin
      sclk = 1'b0; tick;
      sclk = 1'b1; tick;
      chk("R7 fs_tx silent after reselect", fs_tx, 0);
      chk("R7 acq silent after reselect", acq, 0);
    end
    cs_n = 1'b1; tick;
    cs_n = 1'b0; tick;
    chk("R7 mode re-evaluated framed", framed, 1);
    run_frame(1'b0, 16'hC000, 16'h9009, 0, 1'b0);

    summary();
    $finish;
  end
endmodule